// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

A small accumulator processor whose control is a hardwired synchronous state machine. It fetches an instruction word from a single-port word memory. It decodes the word and, when the instruction names a memory location, fetches a second word that holds that location. It then reads the operand, adds it into the accumulator, writes the accumulator out, or redirects the program counter. Then it starts over. A halt instruction, or any opcode the decoder does not know, stops the loop for good until the next reset.

Every step is an explicit register transfer. The memory address register is loaded from the program counter or from the operand-address register. The word returned by memory lands in the memory data register. The opcode and operand-address registers capture their words from the same read. The program counter steps by the word size in bytes (2 for 16-bit words) after each word it fetches. The memory returns read data one cycle after the address appears, and the sequencer spends one wait state on each read to match that.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, the program counter, accumulator, halted flag, zero flag and negative flag all read zero, and the write strobe is low.
- R2: Each fetched word (opcode or operand address) advances the program counter by 2. Execution starts at address 0x0000, and memory is byte-addressed.
- R3: Opcode 0x0099 (add) takes the next word as an address, reads the word stored there, and sets the accumulator to the old accumulator plus that word, modulo 2^16.
- R4: After an add, the negative flag equals bit 15 of the accumulator, and the zero flag is 1 exactly when the accumulator is 0x0000. No other instruction changes either flag.
- R5: Opcode 0x00A5 (store) takes the next word as an address and writes the accumulator there. The write strobe is high for exactly one cycle, and the write data equals the accumulator.
- R6: Opcode 0x00C3 (jump) takes the next word as an address and loads it into the program counter. The next opcode fetch presents that address.
- R7: Opcode 0x0000 (halt) sets the halted flag. From then on the program counter, the memory address and the accumulator hold their values, and no write occurs. The program counter stays at the halt opcode address plus 2.
- R8: Any opcode other than 0x0099, 0x00A5, 0x00C3 and 0x0000 behaves as halt.
- R9: Counted in clock edges from the first opcode fetch, add takes 10 cycles, store 9, jump 8 and halt 4 (up to the edge that sets the halted flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory byte address (memory address register) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_wdata | output | 16 | Write data (memory data register) |
| mem_we | output | 1 | Write strobe, 1 = write this cycle |
| pc_q | output | 16 | Program counter |
| acc_q | output | 16 | Accumulator |
| halted | output | 1 | Halt status bit |
| flag_z | output | 1 | Zero status bit |
| flag_n | output | 1 | Negative status bit |

## Verification
Every instruction has a fixed length: three edges per memory read (address load, wait, capture), one decode edge, and one or two execution edges. A program of add, add, store and halt therefore sets the halted flag on exactly the 33rd edge after reset release. The bench counts edges from release and samples 1 ns after each one. It checks the edge count at which halted rises, and it probes the memory address on the edge just after a jump completes. The write strobe is counted on every sampled cycle, and the program counter and address are watched for several cycles after the halt, so extra writes or a late step are seen where they occur.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int unsigned OPC_HLT = 'h0000;
   localparam int unsigned OPC_ADD = 'h0099;
   localparam int unsigned OPC_STA = 'h00A5;
   localparam int unsigned OPC_JMP = 'h00C3;

   typedef enum logic [3:0] {
      S_F_MAR,   S_F_WAIT,   S_F_LAT,
      S_DECODE,
      S_A_MAR,   S_A_WAIT,   S_A_LAT,
      S_D_MAR,   S_D_WAIT,   S_EXEC,
      S_W_MAR,   S_W_STROBE,
      S_JUMP,
      S_HALT
   } seq_state_t;

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_opa;
      logic cap_word;
      logic cap_op;
      logic cap_opa;
      logic step_pc;
      logic do_add;
      logic mdr_from_acc;
      logic do_jump;
      logic do_halt;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] sum_out,
   output logic              neg_out,
   output logic              zero_out
);
   localparam int MSB = DATA_W - 1;

   assign sum_out  = a_in + b_in;
   assign neg_out  = sum_out[MSB];
   assign zero_out = (sum_out == '0);
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_q,
   output ctrl_t             ctrl,
   output logic              mem_we
);
   seq_state_t st_q, st_nx;
   logic is_add, is_sta, is_jmp;

   assign is_add = (op_q == DATA_W'(OPC_ADD));
   assign is_sta = (op_q == DATA_W'(OPC_STA));
   assign is_jmp = (op_q == DATA_W'(OPC_JMP));

   always_comb begin
      ctrl   = '0;
      mem_we = 1'b0;
      st_nx  = st_q;
      unique case (st_q)
         S_F_MAR:  begin ctrl.mar_from_pc = 1'b1; st_nx = S_F_WAIT; end
         S_F_WAIT: st_nx = S_F_LAT;
         S_F_LAT: begin
            ctrl.cap_word = 1'b1;
            ctrl.cap_op   = 1'b1;
            ctrl.step_pc  = 1'b1;
            st_nx         = S_DECODE;
         end
         S_DECODE: begin
            if (is_add || is_sta || is_jmp) st_nx = S_A_MAR;
            else begin
               ctrl.do_halt = 1'b1;
               st_nx        = S_HALT;
            end
         end
         S_A_MAR:  begin ctrl.mar_from_pc = 1'b1; st_nx = S_A_WAIT; end
         S_A_WAIT: st_nx = S_A_LAT;
         S_A_LAT: begin
            ctrl.cap_word = 1'b1;
            ctrl.cap_opa  = 1'b1;
            ctrl.step_pc  = 1'b1;
            if (is_add)      st_nx = S_D_MAR;
            else if (is_sta) st_nx = S_W_MAR;
            else             st_nx = S_JUMP;
         end
         S_D_MAR:  begin ctrl.mar_from_opa = 1'b1; st_nx = S_D_WAIT; end
         S_D_WAIT: st_nx = S_EXEC;
         S_EXEC: begin
            ctrl.cap_word = 1'b1;
            ctrl.do_add   = 1'b1;
            st_nx         = S_F_MAR;
         end
         S_W_MAR: begin
            ctrl.mar_from_opa = 1'b1;
            ctrl.mdr_from_acc = 1'b1;
            st_nx             = S_W_STROBE;
         end
         S_W_STROBE: begin mem_we = 1'b1; st_nx = S_F_MAR; end
         S_JUMP:     begin ctrl.do_jump = 1'b1; st_nx = S_F_MAR; end
         S_HALT:     st_nx = S_HALT;
         default:    st_nx = S_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= S_F_MAR;
      else        st_q <= st_nx;
   end

   // R9: a fetch is always followed by the wait state
   p_fetch_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.mar_from_pc |=> !ctrl.cap_word && !mem_we);
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] op_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] acc_q,
   output logic              flag_h,
   output logic              flag_z,
   output logic              flag_n
);
   localparam int STEP = DATA_W / 8;
   localparam int MSB  = DATA_W - 1;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be a multiple of 8 and at least 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mdr_q, opa_q, sum;
   logic [ADDR_W-1:0] opa_addr;
   logic              sum_n, sum_z;

   generate
      if (ADDR_W <= DATA_W) begin : g_addr_trunc
         assign opa_addr = opa_q[ADDR_W-1:0];
      end else begin : g_addr_zext
         assign opa_addr = {{(ADDR_W-DATA_W){1'b0}}, opa_q};
      end
   endgenerate

   acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
      .a_in(acc_q), .b_in(mem_rdata),
      .sum_out(sum), .neg_out(sum_n), .zero_out(sum_z)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         mar_q  <= '0;
         mdr_q  <= '0;
         op_q   <= '0;
         opa_q  <= '0;
         acc_q  <= '0;
         flag_h <= 1'b0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else begin
         if (ctrl.mar_from_pc)  mar_q <= pc_q;
         if (ctrl.mar_from_opa) mar_q <= opa_addr;
         if (ctrl.cap_word)     mdr_q <= mem_rdata;
         if (ctrl.mdr_from_acc) mdr_q <= acc_q;
         if (ctrl.cap_op)       op_q  <= mem_rdata;
         if (ctrl.cap_opa)      opa_q <= mem_rdata;
         if (ctrl.step_pc)      pc_q  <= pc_q + ADDR_W'(STEP);
         if (ctrl.do_jump)      pc_q  <= opa_addr;
         if (ctrl.do_add) begin
            acc_q  <= sum;
            flag_n <= sum_n;
            flag_z <= sum_z;
         end
         if (ctrl.do_halt)      flag_h <= 1'b1;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;

   // R2: program counter steps by one word per fetched word
   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.step_pc |=> pc_q == $past(pc_q) + ADDR_W'(STEP));
   // R6: jump loads the operand address
   p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.do_jump |=> pc_q == $past(opa_addr));
   // R4: flags track the accumulator after an add
   p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.do_add |=> (flag_n == acc_q[MSB]) && (flag_z == (acc_q == '0)));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] acc_q,
   output logic              halted,
   output logic              flag_z,
   output logic              flag_n
);
   ctrl_t             ctrl;
   logic [DATA_W-1:0] op_q;

   acc_cpu_seq #(.DATA_W(DATA_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .op_q(op_q), .ctrl(ctrl), .mem_we(mem_we)
   );

   acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .op_q(op_q),
      .pc_q(pc_q), .acc_q(acc_q),
      .flag_h(halted), .flag_z(flag_z), .flag_n(flag_n)
   );

   // R7: halt is sticky and freezes the machine
   p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && !mem_we && $stable(pc_q) && $stable(mem_addr) && $stable(acc_q));
   // R5: write strobe lasts one cycle
   p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   // R5: written data is the accumulator
   p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata == acc_q);
endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr, mem_rdata, mem_wdata, pc_q, acc_q;
   logic        mem_we, halted, flag_z, flag_n;

   logic [15:0] mem [0:127];
   logic        ld_en = 1'b0;
   logic [6:0]  ld_idx = '0;
   logic [15:0] ld_dat = '0;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   acc_cpu dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_q(pc_q), .acc_q(acc_q),
      .halted(halted), .flag_z(flag_z), .flag_n(flag_n)
   );

   always @(posedge clk) begin
      if (ld_en)       mem[ld_idx] <= ld_dat;
      else if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:1]];
   end

   // columns: operand a, operand b, expected sum, expected N, expected Z
   localparam logic [15:0] VEC [0:5][0:4] = '{
      '{16'h0001, 16'h0005, 16'h0006, 16'h0, 16'h0},
      '{16'h7FFF, 16'h0001, 16'h8000, 16'h1, 16'h0},
      '{16'hFFFF, 16'h0001, 16'h0000, 16'h0, 16'h1},
      '{16'h1234, 16'h8000, 16'h9234, 16'h1, 16'h0},
      '{16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h1},
      '{16'h4000, 16'h3FFF, 16'h7FFF, 16'h0, 16'h0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [15:0] byte_addr, input logic [15:0] dat);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = byte_addr[7:1]; ld_dat = dat;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_mem();
      rst_n = 1'b0;
      for (int i = 0; i < 128; i++) poke(16'(i * 2), 16'h0000);
   endtask

   task automatic run(input int probe, output int cyc, output int wes,
                      output logic [15:0] probe_addr);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0; wes = 0; probe_addr = '0;
      while (!halted && cyc < 400) begin
         @(posedge clk);
         #1;
         cyc++;
         if (mem_we) wes++;
         if (cyc == probe) probe_addr = mem_addr;
      end
   endtask

   task automatic hold_check();
      logic [15:0] pc0, a0;
      pc0 = pc_q; a0 = mem_addr;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk);
         #1;
         chk("R7 pc frozen", pc_q, pc0);
         chk("R7 addr frozen", mem_addr, a0);
         chk("R7 no write", mem_we, 1'b0);
      end
   endtask

   initial begin
      #1ms;
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int cyc, wes;
      logic [15:0] pa;

      // R1: reset state
      clear_mem();
      #1;
      chk("R1 pc", pc_q, 16'h0);
      chk("R1 acc", acc_q, 16'h0);
      chk("R1 halted", halted, 1'b0);
      chk("R1 z", flag_z, 1'b0);
      chk("R1 n", flag_n, 1'b0);
      chk("R1 we", mem_we, 1'b0);

      // vector table: ADD 0x40; ADD 0x42; STA 0x44; HLT
      for (int v = 0; v < 6; v++) begin
         clear_mem();
         poke(16'h0000, 16'h0099); poke(16'h0002, 16'h0040);
         poke(16'h0004, 16'h0099); poke(16'h0006, 16'h0042);
         poke(16'h0008, 16'h00A5); poke(16'h000A, 16'h0044);
         poke(16'h000C, 16'h0000);
         poke(16'h0040, VEC[v][0]); poke(16'h0042, VEC[v][1]);
         run(1, cyc, wes, pa);
         chk("R3 sum", acc_q, VEC[v][2]);
         chk("R4 n flag", flag_n, VEC[v][3][0]);
         chk("R4 z flag", flag_z, VEC[v][4][0]);
         chk("R5 stored word", mem[7'h22], VEC[v][2]);
         chk("R5 one write cycle", wes, 1);
         chk("R2 first fetch addr", pa, 16'h0000);
         chk("R7 pc after halt", pc_q, 16'h000E);
         chk("R9 cycles add+add+sta+hlt", cyc, 33);
         chk("R7 halted", halted, 1'b1);
      end
      hold_check();

      // R6: JMP 0x20; at 0x20: ADD 0x40; HLT
      clear_mem();
      poke(16'h0000, 16'h00C3); poke(16'h0002, 16'h0020);
      poke(16'h0004, 16'h0099); poke(16'h0006, 16'h0040);
      poke(16'h0020, 16'h0099); poke(16'h0022, 16'h0040);
      poke(16'h0024, 16'h0000);
      poke(16'h0040, 16'h0007);
      run(9, cyc, wes, pa);
      chk("R6 fetch at jump target", pa, 16'h0020);
      chk("R6 acc after jump", acc_q, 16'h0007);
      chk("R6 pc after halt", pc_q, 16'h0026);
      chk("R9 cycles jmp+add+hlt", cyc, 22);
      chk("R6 no write", wes, 0);

      // R8: unknown opcode halts
      clear_mem();
      poke(16'h0000, 16'h1234); poke(16'h0002, 16'h0099);
      poke(16'h0004, 16'h0040); poke(16'h0040, 16'h0005);
      run(1, cyc, wes, pa);
      chk("R8 halted", halted, 1'b1);
      chk("R8 cycles", cyc, 4);
      chk("R8 pc", pc_q, 16'h0002);
      chk("R8 acc untouched", acc_q, 16'h0000);
      hold_check();

      // R7: bare halt
      clear_mem();
      run(1, cyc, wes, pa);
      chk("R7 halt cycles", cyc, 4);
      chk("R7 halt pc", pc_q, 16'h0002);
      chk("R4 flags untouched z", flag_z, 1'b0);
      chk("R4 flags untouched n", flag_n, 1'b0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule